// File: doc/BRIEF.md
# Condition Register Compare Unit

This block keeps a 32-bit condition register split into eight 4-bit fields, numbered 0 to 7. A compare request sets one chosen field from the result of comparing two operands. The first operand is always a register value. The second is either another register value or a 16-bit immediate. The compare can be signed (two's complement) or unsigned. Branch logic downstream reads the whole register through a combinational output.

Arithmetic results change the register only when a record request comes with them. A record request writes field 0 with the signed comparison of the result against zero. A third operation sets one register bit to the XOR of two other register bits. This operation sets and clears single condition bits. All writes take effect on the rising clock edge.

Top module: `cr_compare_unit`

## Requirements
- R1: A synchronous active-high `rst` clears all 32 bits of the condition register to zero on the next rising edge.
- R2: Register bits are numbered big-endian, so bit index i is vector bit `31-i`. Field k covers bit indices 4k to 4k+3, which is `cr_out[31-4k -: 4]`. A compare writes only the field chosen by `cmp_field` and leaves every other field unchanged.
- R3: Within a written field, the field's bit 0 (its most significant vector bit) is "less than", bit 1 is "greater than" and bit 2 is "equal". Exactly one of these three is set. Bit 3 is written with zero.
- R4: With `cmp_signed`=1 and `cmp_use_imm`=0, `cmp_a` and `cmp_b` are compared as 32-bit two's complement numbers.
- R5: With `cmp_signed`=0 and `cmp_use_imm`=0, `cmp_a` and `cmp_b` are compared as unsigned numbers.
- R6: With `cmp_use_imm`=1 and `cmp_signed`=1, the second operand is `cmp_imm` sign-extended to 32 bits, and `cmp_b` is ignored.
- R7: With `cmp_use_imm`=1 and `cmp_signed`=0, the second operand is `cmp_imm` zero-extended to 32 bits.
- R8: When `rec_en`=1, field 0 is written with the signed comparison of `rec_value` against zero, using the encoding of R3. When `rec_en`=0, `rec_value` has no effect.
- R9: In a cycle where `cmp_en`, `rec_en` and `bx_en` are all 0, the register keeps its value.
- R10: When `bx_en`=1, bit index `bx_dst` is written with the XOR of bit indices `bx_src_a` and `bx_src_b`. The source bits are read from the register value before the edge. All other bits are unchanged.
- R11: A bit XOR whose two source indices are equal clears the destination bit.
- R12: When several writes hit the same bits in one cycle, the compare field write has priority over the bit XOR, and the bit XOR has priority over the record write.
- R13: `cr_out` always shows the current register contents, with no added cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmp_en | input | 1 | Compare request |
| cmp_signed | input | 1 | 1 = signed compare, 0 = unsigned compare |
| cmp_use_imm | input | 1 | 1 = second operand comes from `cmp_imm` |
| cmp_field | input | 3 | Destination field index of the compare |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand (register form) |
| cmp_imm | input | 16 | Immediate second operand |
| rec_en | input | 1 | Record request for field 0 |
| rec_value | input | 32 | Arithmetic result compared against zero |
| bx_en | input | 1 | Condition-bit XOR request |
| bx_src_a | input | 5 | First source bit index |
| bx_src_b | input | 5 | Second source bit index |
| bx_dst | input | 5 | Destination bit index |
| cr_out | output | 32 | Current condition register contents |

## Verification
All state in this block is the register that `cr_out` shows, so a wrong bit is visible at the ports in the cycle after the edge that wrote it. A field placed at the wrong position, a swapped less/greater pair, or a wrong immediate extension therefore shows up as a mismatch one clock after the faulty operation. The mismatch stays visible until that bit is written again. Bit XOR results depend on earlier contents, so a bad value written earlier can also spread into later XOR results. Comparing every cycle catches it at the first wrong edge.

// File: rtl/crcu_pkg.sv
`timescale 1ns/1ps
package crcu_pkg;

    localparam int FIELD_W = 4;

    typedef logic [FIELD_W-1:0] crfield_t;

    // Packs a field as {less, greater, equal, overflow-summary}.
    // The most significant vector bit is the field's bit 0.
    function automatic crfield_t make_field(input logic lt, input logic gt, input logic eq);
        crfield_t f;
        f = {lt, gt, eq, 1'b0};
        return f;
    endfunction

endpackage

// File: rtl/crcu_cmp.sv
`timescale 1ns/1ps
module crcu_cmp
    import crcu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic              is_signed,
    output crfield_t          result
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] rhs;
    logic              lt, gt, eq;

    always_comb begin
        if (use_imm) begin
            if (is_signed) rhs = {{EXT_W{imm[IMM_W-1]}}, imm};
            else           rhs = {{EXT_W{1'b0}}, imm};
        end else begin
            rhs = op_b;
        end
        eq = (op_a == rhs);
        if (is_signed) lt = ($signed(op_a) < $signed(rhs));
        else           lt = (op_a < rhs);
        gt = !lt && !eq;
        result = make_field(lt, gt, eq);
    end

endmodule

// File: rtl/crcu_bitxor.sv
`timescale 1ns/1ps
module crcu_bitxor #(
    parameter int CR_W = 32,
    localparam int BSEL_W = $clog2(CR_W)
) (
    input  logic [CR_W-1:0]   cr,
    input  logic [BSEL_W-1:0] src_a,
    input  logic [BSEL_W-1:0] src_b,
    output logic              result
);
    logic bit_a, bit_b;

    // Big-endian bit numbering: index i maps to vector bit CR_W-1-i.
    always_comb begin
        bit_a = 1'b0;
        bit_b = 1'b0;
        for (int i = 0; i < CR_W; i++) begin
            if (src_a == BSEL_W'(i)) bit_a = cr[CR_W-1-i];
            if (src_b == BSEL_W'(i)) bit_b = cr[CR_W-1-i];
        end
        result = bit_a ^ bit_b;
    end

endmodule

// File: rtl/cr_compare_unit.sv
`timescale 1ns/1ps
module cr_compare_unit
    import crcu_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int IMM_W      = 16,
    parameter int NUM_FIELDS = 8,
    localparam int CR_W   = NUM_FIELDS * FIELD_W,
    localparam int FSEL_W = $clog2(NUM_FIELDS),
    localparam int BSEL_W = $clog2(CR_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_en,
    input  logic              cmp_signed,
    input  logic              cmp_use_imm,
    input  logic [FSEL_W-1:0] cmp_field,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic [IMM_W-1:0]  cmp_imm,
    input  logic              rec_en,
    input  logic [DATA_W-1:0] rec_value,
    input  logic              bx_en,
    input  logic [BSEL_W-1:0] bx_src_a,
    input  logic [BSEL_W-1:0] bx_src_b,
    input  logic [BSEL_W-1:0] bx_dst,
    output logic [CR_W-1:0]   cr_out
);
    typedef struct packed {
        logic [CR_W-1:0] cr;
    } state_t;

    state_t   state_d, state_q;
    crfield_t cmp_result;
    crfield_t rec_result;
    logic     bx_bit;

    crcu_cmp #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_cmp (
        .op_a      (cmp_a),
        .op_b      (cmp_b),
        .imm       (cmp_imm),
        .use_imm   (cmp_use_imm),
        .is_signed (cmp_signed),
        .result    (cmp_result)
    );

    // Record path: signed compare of the arithmetic result against zero.
    crcu_cmp #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_rec (
        .op_a      (rec_value),
        .op_b      ('0),
        .imm       ('0),
        .use_imm   (1'b0),
        .is_signed (1'b1),
        .result    (rec_result)
    );

    crcu_bitxor #(.CR_W(CR_W)) u_bx (
        .cr     (state_q.cr),
        .src_a  (bx_src_a),
        .src_b  (bx_src_b),
        .result (bx_bit)
    );

    // Writes are applied lowest priority first: record, bit XOR, compare.
    always_comb begin
        state_d = state_q;
        if (rec_en) begin
            state_d.cr[CR_W-1 -: FIELD_W] = rec_result;
        end
        if (bx_en) begin
            for (int i = 0; i < CR_W; i++) begin
                if (bx_dst == BSEL_W'(i)) state_d.cr[CR_W-1-i] = bx_bit;
            end
        end
        if (cmp_en) begin
            for (int f = 0; f < NUM_FIELDS; f++) begin
                if (cmp_field == FSEL_W'(f)) state_d.cr[CR_W-1-FIELD_W*f -: FIELD_W] = cmp_result;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign cr_out = state_q.cr;

endmodule

// File: rtl/crcu_checker.sv
`timescale 1ns/1ps
module crcu_checker
    import crcu_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NUM_FIELDS = 8,
    localparam int CR_W   = NUM_FIELDS * FIELD_W,
    localparam int FSEL_W = $clog2(NUM_FIELDS),
    localparam int BSEL_W = $clog2(CR_W)
) (
    input logic              clk,
    input logic              rst,
    input logic              cmp_en,
    input logic [FSEL_W-1:0] cmp_field,
    input logic              rec_en,
    input logic [DATA_W-1:0] rec_value,
    input logic              bx_en,
    input logic [BSEL_W-1:0] bx_src_a,
    input logic [BSEL_W-1:0] bx_src_b,
    input logic [BSEL_W-1:0] bx_dst,
    input logic [CR_W-1:0]   cr_out
);
    logic [FSEL_W-1:0] dst_q;
    logic [BSEL_W-1:0] bdst_q;
    logic [CR_W-1:0]   fld_shift, bit_shift, keep_mask;
    crfield_t          fld_at_dst;

    always_ff @(posedge clk) begin
        dst_q  <= cmp_field;
        bdst_q <= bx_dst;
    end

    always_comb begin
        fld_shift  = cr_out << (FIELD_W * int'(dst_q));
        fld_at_dst = fld_shift[CR_W-1 -: FIELD_W];
        bit_shift  = cr_out << bdst_q;
        keep_mask  = '1;
        for (int f = 0; f < NUM_FIELDS; f++) begin
            if (dst_q == FSEL_W'(f)) keep_mask[CR_W-1-FIELD_W*f -: FIELD_W] = '0;
        end
    end

    // R3
    cmp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_en |=> ($countones(fld_at_dst[FIELD_W-1:1]) == 1) && (fld_at_dst[0] == 1'b0));

    // R2
    other_fields_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_en && !rec_en && !bx_en |=> ((cr_out ^ $past(cr_out)) & keep_mask) == '0);

    // R8
    rec_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rec_en && !cmp_en && !bx_en |=>
            cr_out[CR_W-1 -: FIELD_W] == {$past(rec_value[DATA_W-1]),
                                          !$past(rec_value[DATA_W-1]) && ($past(rec_value) != '0),
                                          $past(rec_value) == '0, 1'b0});

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cmp_en && !rec_en && !bx_en |=> $stable(cr_out));

    // R11
    self_xor_chk: assert property (@(posedge clk) disable iff (rst)
        bx_en && (bx_src_a == bx_src_b) && !cmp_en |=> bit_shift[CR_W-1] == 1'b0);

endmodule

bind cr_compare_unit crcu_checker #(.DATA_W(DATA_W), .NUM_FIELDS(NUM_FIELDS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmp_en    (cmp_en),
    .cmp_field (cmp_field),
    .rec_en    (rec_en),
    .rec_value (rec_value),
    .bx_en     (bx_en),
    .bx_src_a  (bx_src_a),
    .bx_src_b  (bx_src_b),
    .bx_dst    (bx_dst),
    .cr_out    (cr_out)
);

// File: tb/tb_cr_compare_unit.sv
`timescale 1ns/1ps
module tb_cr_compare_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmp_en, cmp_signed, cmp_use_imm;
    logic [2:0]  cmp_field;
    logic [31:0] cmp_a, cmp_b;
    logic [15:0] cmp_imm;
    logic        rec_en;
    logic [31:0] rec_value;
    logic        bx_en;
    logic [4:0]  bx_src_a, bx_src_b, bx_dst;
    logic [31:0] cr_out;

    bit [31:0] model;
    int        n_vec = 0;
    int        n_bad = 0;
    bit        done  = 1'b0;

    always #10 clk = ~clk;

    cr_compare_unit dut (
        .clk(clk), .rst(rst),
        .cmp_en(cmp_en), .cmp_signed(cmp_signed), .cmp_use_imm(cmp_use_imm),
        .cmp_field(cmp_field), .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_imm(cmp_imm),
        .rec_en(rec_en), .rec_value(rec_value),
        .bx_en(bx_en), .bx_src_a(bx_src_a), .bx_src_b(bx_src_b), .bx_dst(bx_dst),
        .cr_out(cr_out)
    );

    // Field encoding from R3: {lt, gt, eq, 0}, lt in the top vector bit.
    function automatic bit [3:0] ref_field(bit [31:0] a, bit [31:0] b, bit sgn);
        longint sa, sb;
        sa = sgn ? longint'(int'(a)) : longint'(a);
        sb = sgn ? longint'(int'(b)) : longint'(b);
        if (sa < sb)       return 4'b1000;
        else if (sa > sb)  return 4'b0100;
        else               return 4'b0010;
    endfunction

    function automatic bit [31:0] predict();
        bit [31:0] nx;
        bit [31:0] rhs;
        nx = model;
        if (rst) return 32'h0;
        if (rec_en) nx[31 -: 4] = ref_field(rec_value, 32'h0, 1'b1);
        if (bx_en)  nx[31 - int'(bx_dst)] = model[31 - int'(bx_src_a)] ^ model[31 - int'(bx_src_b)];
        if (cmp_en) begin
            if (cmp_use_imm) rhs = cmp_signed ? {{16{cmp_imm[15]}}, cmp_imm} : {16'h0, cmp_imm};
            else             rhs = cmp_b;
            nx[31 - 4*int'(cmp_field) -: 4] = ref_field(cmp_a, rhs, cmp_signed);
        end
        return nx;
    endfunction

    task automatic idle();
        rst = 1'b0; cmp_en = 1'b0; rec_en = 1'b0; bx_en = 1'b0;
    endtask

    task automatic step(string tag);
        bit [31:0] exp;
        exp = predict();
        @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (cr_out !== exp) begin
            n_bad++;
            $display("FAIL %s: cr_out=%h expected %h", tag, cr_out, exp);
        end
        model = exp;
        idle();
    endtask

    task automatic do_cmp(bit sgn, bit imm_form, int fld, bit [31:0] a, bit [31:0] b, bit [15:0] im, string tag);
        cmp_en = 1'b1; cmp_signed = sgn; cmp_use_imm = imm_form; cmp_field = 3'(fld);
        cmp_a = a; cmp_b = b; cmp_imm = im;
        step(tag);
    endtask

    task automatic do_rec(bit [31:0] v, string tag);
        rec_en = 1'b1; rec_value = v;
        step(tag);
    endtask

    task automatic do_bx(int sa, int sb, int d, string tag);
        bx_en = 1'b1; bx_src_a = 5'(sa); bx_src_b = 5'(sb); bx_dst = 5'(d);
        step(tag);
    endtask

    initial begin
        #3000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model = 32'h0;
        idle();
        cmp_signed = 1'b0; cmp_use_imm = 1'b0; cmp_field = '0;
        cmp_a = '0; cmp_b = '0; cmp_imm = '0; rec_value = '0;
        bx_src_a = '0; bx_src_b = '0; bx_dst = '0;
        @(negedge clk);
        rst = 1'b1; step("R1 reset");
        rst = 1'b1; step("R1 reset hold");

        // R4 signed register compares
        do_cmp(1, 0, 2, 32'hFFFF_FFFB, 32'd3, 16'h0, "R4 neg<pos");
        do_cmp(1, 0, 5, 32'd7, 32'd7, 16'h0, "R4 equal");
        do_cmp(1, 0, 7, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, "R4 max>min");
        // R5 unsigned register compares
        do_cmp(0, 0, 2, 32'hFFFF_FFFB, 32'd3, 16'h0, "R5 big>small");
        do_cmp(0, 0, 3, 32'd1, 32'h8000_0000, 16'h0, "R5 less");
        // R6 / R7 immediate extension, cmp_b ignored
        do_cmp(1, 1, 1, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, "R6 sext equal");
        do_cmp(1, 1, 4, 32'h0000_8000, 32'hFFFF_FFFF, 16'h8000, "R6 sext greater");
        do_cmp(0, 1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, "R7 zext greater");
        do_cmp(0, 1, 6, 32'h0000_FFFF, 32'h0, 16'hFFFF, "R7 zext equal");
        // R8 record path
        do_rec(32'h8000_0001, "R8 negative");
        do_rec(32'h0, "R8 zero");
        do_rec(32'h0000_0042, "R8 positive");
        rec_value = 32'h8000_0000; step("R8 record off ignored");
        // R9 hold with operand noise
        cmp_a = 32'h1234_5678; cmp_b = 32'h0; step("R9 hold");
        // R10 / R11 bit XOR
        do_bx(0, 9, 30, "R10 xor set");
        do_bx(30, 1, 17, "R10 xor chain");
        do_bx(17, 17, 17, "R11 self clear");
        do_bx(4, 4, 11, "R11 clear other bit");
        // R12 priorities
        cmp_en = 1'b1; cmp_signed = 1'b1; cmp_use_imm = 1'b0; cmp_field = 3'd0;
        cmp_a = 32'd0; cmp_b = 32'd5; rec_en = 1'b1; rec_value = 32'd9;
        step("R12 compare over record");
        cmp_en = 1'b1; cmp_field = 3'd3; cmp_a = 32'd5; cmp_b = 32'd5;
        bx_en = 1'b1; bx_src_a = 5'd9; bx_src_b = 5'd0; bx_dst = 5'd14;
        step("R12 compare over xor");
        bx_en = 1'b1; bx_src_a = 5'd20; bx_src_b = 5'd20; bx_dst = 5'd2;
        rec_en = 1'b1; rec_value = 32'd0;
        step("R12 xor over record");

        // Random mix: R2/R4/R5/R6/R7/R10/R13 checked against the model each cycle
        for (int k = 0; k < 4000; k++) begin
            cmp_en      = ($urandom % 3) != 0;
            cmp_signed  = 1'($urandom);
            cmp_use_imm = 1'($urandom);
            cmp_field   = 3'($urandom);
            cmp_a       = $urandom;
            cmp_b       = (($urandom % 4) == 0) ? cmp_a : $urandom;
            cmp_imm     = (($urandom % 4) == 0) ? cmp_a[15:0] : 16'($urandom);
            rec_en      = ($urandom % 3) == 0;
            rec_value   = (($urandom % 5) == 0) ? 32'h0 : $urandom;
            bx_en       = ($urandom % 3) == 0;
            bx_src_a    = 5'($urandom);
            bx_src_b    = 5'($urandom);
            bx_dst      = 5'($urandom);
            rst         = ($urandom % 500) == 0;
            step("R2/R13 random");
        end

        rst = 1'b1; step("R1 final reset");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule